// File: doc/BRIEF.md
# Speculation Recovery and Slow-Start Controller

This block sits at system level beside the checkpoint machinery. It watches the coherence transaction that each processor has outstanding and gathers the mis-speculation flags that the coherence controllers raise. When a transaction stays outstanding too long, the block assumes a deadlock. When a controller flags an illegal message reordering or an unhandled protocol race, the block treats it as a mis-speculation. In either case it sends a single recovery pulse to the rollback logic. It then waits for that logic to report that the rollback has finished.

Each recovery that follows a quiet period ends in a plain resume. A recovery that a reordering flag caused also turns off adaptive routing for a fixed number of checkpoint intervals, so that messages travel along one path in order while the interrupted work runs again. A second recovery that arrives soon after the previous one counts as a recurrence. In that case the block enters slow-start: it lowers the limit on outstanding coherence transactions to a small value for a fixed number of intervals, and then restores the full limit.

All time windows are counted in checkpoint intervals. One interval is a parameter number of clock cycles, and a single free-running timer supplies the interval boundaries to every counter in the block.

Top module: `spec_recovery_ctrl`

## Requirements
- R1: After reset, `recover_req` and `adaptive_route_dis` are 0 and `txn_limit` equals `MAX_OUTSTANDING`.
- R2: While no recovery is pending, a 1 on any bit of `misspec_order` or `misspec_race` at a clock edge drives `recover_req` to 1 in the following cycle, and only for that one cycle.
- R3: Between a `recover_req` pulse and the `recover_done` that answers it, further flags and timeouts have no effect. They raise no pulse, and a reordering flag that arrives in this window does not disable adaptive routing.
- R4: A `recover_done` that arrives while no recovery is pending is ignored. It raises no pulse, changes no output, and does not count as a recovery when the next recovery is judged for recurrence.
- R5: If bit k of `txn_busy` stays 1 across `TIMEOUT_IVALS` interval boundaries while `txn_done[k]` stays 0, a recovery is requested. With the default of three, the pulse appears between 2·CKPT_CYCLES+1 and 3·CKPT_CYCLES+2 cycles after `txn_busy[k]` rises.
- R6: A `txn_done[k]` pulse, or `txn_busy[k]` at 0, returns processor k's watchdog count to zero. Transactions that keep completing within two intervals never time out.
- R7: When a recovery was triggered by `misspec_order`, `adaptive_route_dis` becomes 1 at the clock edge that samples `recover_done`. It stays 1 for `ROUTE_HOLD_IVALS` interval boundaries and then returns to 0.
- R8: A recovery triggered only by a race flag or by a timeout leaves `adaptive_route_dis` at 0.
- R9: A recovery with no prior recovery completed within the last `RECUR_WIN_IVALS` intervals resumes normally: `txn_limit` stays `MAX_OUTSTANDING`.
- R10: A recovery triggered while fewer than `RECUR_WIN_IVALS` interval boundaries have passed since the previous `recover_done` enters slow-start. `txn_limit` becomes `SLOW_LIMIT` at the edge that samples `recover_done`, stays there for `SLOW_HOLD_IVALS` interval boundaries, and then returns to `MAX_OUTSTANDING`.
- R11: All watchdogs are cleared while a recovery is pending, so a transaction that is still outstanding after a rollback gets a full timeout window again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| txn_busy | input | NUM_PROC | Per processor: a coherence transaction is outstanding |
| txn_done | input | NUM_PROC | Per processor: the outstanding transaction completed this cycle |
| misspec_order | input | NUM_PROC | Per controller: an illegal message reordering was detected |
| misspec_race | input | NUM_PROC | Per controller: an unhandled protocol race was detected |
| recover_done | input | 1 | The rollback logic has finished restoring state |
| recover_req | output | 1 | One-cycle request to roll back to the last checkpoint |
| adaptive_route_dis | output | 1 | 1 forces the interconnect onto static routing |
| txn_limit | output | $clog2(MAX_OUTSTANDING+1) | Number of coherence transactions allowed to be outstanding |

## Verification
Three kinds of internal fault are visible at the ports. A sequencer stuck in the waiting state shows as a missing pulse on the next trigger. A sequencer that left the waiting state too early shows as a second pulse before `recover_done`. Either fault appears within one cycle of the stimulus. A wrong recurrence window or wrong hold counts show on `txn_limit` and `adaptive_route_dis` from the edge that samples `recover_done`, or at the interval boundary where those outputs should drop back. A watchdog that counts wrongly, or that is not cleared, moves the timeout pulse outside its window of one interval. Such a fault shows within about three intervals of the transaction starting.

// File: rtl/sr_pkg.sv
// Shared types for the speculation recovery controller.
// Assumes: nothing beyond IEEE 1800-2017.
package sr_pkg;

    // Recovery sequencer states
    typedef enum logic {
        SR_RUN  = 1'b0,   // normal execution, triggers accepted
        SR_WAIT = 1'b1    // rollback requested, awaiting completion
    } sr_state_e;

endpackage

// File: rtl/sr_interval_timer.sv
// Free-running checkpoint interval timer.
// Produces a one-cycle tick on the last cycle of every interval of
// CKPT_CYCLES clocks. Assumes CKPT_CYCLES >= 2.
module sr_interval_timer #(
    parameter int CKPT_CYCLES = 100000
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int CW = $clog2(CKPT_CYCLES);
    localparam logic [CW-1:0] LAST = CW'(CKPT_CYCLES - 1);

    logic [CW-1:0] cyc_q;

    // Count clocks within the current interval, wrapping at the end
    always_ff @(posedge clk) begin
        if (!rst_n)           cyc_q <= '0;
        else if (cyc_q == LAST) cyc_q <= '0;
        else                  cyc_q <= cyc_q + 1'b1;
    end

    assign tick = (cyc_q == LAST);

endmodule

// File: rtl/sr_txn_watchdog.sv
// Per-processor transaction watchdog.
// Counts interval boundaries seen while a transaction is outstanding;
// flags a timeout once TIMEOUT_IVALS boundaries have passed without a
// completion. Assumes busy is held for the life of the transaction.
module sr_txn_watchdog #(
    parameter int TIMEOUT_IVALS = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic busy,
    input  logic done,
    input  logic clr,
    output logic timed_out
);
    localparam int WW = $clog2(TIMEOUT_IVALS + 1);
    localparam logic [WW-1:0] LIMIT = WW'(TIMEOUT_IVALS);

    logic [WW-1:0] ivals_q;

    // Interval count for the outstanding transaction, saturating at the limit
    always_ff @(posedge clk) begin
        if (!rst_n)                   ivals_q <= '0;
        else if (clr || !busy || done) ivals_q <= '0;
        else if (tick && ivals_q != LIMIT) ivals_q <= ivals_q + 1'b1;
    end

    assign timed_out = busy && (ivals_q == LIMIT);

endmodule

// File: rtl/sr_recovery_fsm.sv
// Recovery sequencer with forward-progress escalation.
// Issues one rollback pulse per accepted trigger, ignores triggers until
// completion, then applies routing-disable and slow-start holds and opens
// a recurrence window. All holds count interval ticks in normal state.
// Assumes recover_done answers each pulse exactly once.
module sr_recovery_fsm
    import sr_pkg::*;
#(
    parameter int ROUTE_HOLD_IVALS = 4,
    parameter int SLOW_HOLD_IVALS  = 8,
    parameter int RECUR_WIN_IVALS  = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic any_order,
    input  logic any_race,
    input  logic any_timeout,
    input  logic recover_done,
    output logic recover_req,
    output logic route_dis,
    output logic slow_mode,
    output logic wd_clr
);
    localparam int RW = $clog2(ROUTE_HOLD_IVALS + 1);
    localparam int SW = $clog2(SLOW_HOLD_IVALS + 1);
    localparam int WW = $clog2(RECUR_WIN_IVALS + 1);
    localparam logic [RW-1:0] ROUTE_LOAD = RW'(ROUTE_HOLD_IVALS);
    localparam logic [SW-1:0] SLOW_LOAD  = SW'(SLOW_HOLD_IVALS);
    localparam logic [WW-1:0] WIN_LOAD   = WW'(RECUR_WIN_IVALS);

    sr_state_e     state_q;
    logic          req_q;
    logic          order_cause_q;
    logic          recur_q;
    logic [RW-1:0] route_cnt_q;
    logic [SW-1:0] slow_cnt_q;
    logic [WW-1:0] win_cnt_q;
    logic          trigger;

    assign trigger = any_order || any_race || any_timeout;

    // Sequencer state, request pulse and captured cause of the recovery
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q       <= SR_RUN;
            req_q         <= 1'b0;
            order_cause_q <= 1'b0;
            recur_q       <= 1'b0;
        end else begin
            req_q <= 1'b0;
            case (state_q)
                SR_RUN: if (trigger) begin
                    state_q       <= SR_WAIT;
                    req_q         <= 1'b1;
                    order_cause_q <= any_order;
                    recur_q       <= (win_cnt_q != '0);
                end
                SR_WAIT: if (recover_done) state_q <= SR_RUN;
                default: state_q <= SR_RUN;
            endcase
        end
    end

    // Hold and window counters: load on completion, count down on ticks
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            route_cnt_q <= '0;
            slow_cnt_q  <= '0;
            win_cnt_q   <= '0;
        end else if (state_q == SR_WAIT) begin
            if (recover_done) begin
                win_cnt_q <= WIN_LOAD;
                if (order_cause_q) route_cnt_q <= ROUTE_LOAD;
                if (recur_q)       slow_cnt_q  <= SLOW_LOAD;
            end
        end else if (tick) begin
            if (route_cnt_q != '0) route_cnt_q <= route_cnt_q - 1'b1;
            if (slow_cnt_q  != '0) slow_cnt_q  <= slow_cnt_q  - 1'b1;
            if (win_cnt_q   != '0) win_cnt_q   <= win_cnt_q   - 1'b1;
        end
    end

    assign recover_req = req_q;
    assign route_dis   = (route_cnt_q != '0);
    assign slow_mode   = (slow_cnt_q  != '0);
    assign wd_clr      = (state_q == SR_WAIT);

endmodule

// File: rtl/spec_recovery_ctrl.sv
// Speculation recovery and slow-start controller (top).
// Combines a shared interval timer, one watchdog per processor and the
// recovery sequencer. Drives the rollback pulse, the adaptive-routing
// disable and the outstanding-transaction limit.
// Assumes all inputs are synchronous to clk.
module spec_recovery_ctrl #(
    parameter int NUM_PROC         = 4,
    parameter int CKPT_CYCLES      = 100000,
    parameter int TIMEOUT_IVALS    = 3,
    parameter int ROUTE_HOLD_IVALS = 4,
    parameter int SLOW_HOLD_IVALS  = 8,
    parameter int RECUR_WIN_IVALS  = 16,
    parameter int MAX_OUTSTANDING  = 16,
    parameter int SLOW_LIMIT       = 1,
    localparam int LIMIT_W         = $clog2(MAX_OUTSTANDING + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PROC-1:0] txn_busy,
    input  logic [NUM_PROC-1:0] txn_done,
    input  logic [NUM_PROC-1:0] misspec_order,
    input  logic [NUM_PROC-1:0] misspec_race,
    input  logic                recover_done,
    output logic                recover_req,
    output logic                adaptive_route_dis,
    output logic [LIMIT_W-1:0]  txn_limit
);
    localparam logic [LIMIT_W-1:0] FULL_V = LIMIT_W'(MAX_OUTSTANDING);
    localparam logic [LIMIT_W-1:0] SLOW_V = LIMIT_W'(SLOW_LIMIT);

    logic                tick;
    logic                wd_clr;
    logic                slow_mode;
    logic                timeout_any;
    logic [NUM_PROC-1:0] timeout_vec;

    sr_interval_timer #(.CKPT_CYCLES(CKPT_CYCLES)) u_timer (
        .clk  (clk),
        .rst_n(rst_n),
        .tick (tick)
    );

    // One watchdog per processor
    for (genvar p = 0; p < NUM_PROC; p++) begin : g_wd
        sr_txn_watchdog #(.TIMEOUT_IVALS(TIMEOUT_IVALS)) u_wd (
            .clk      (clk),
            .rst_n    (rst_n),
            .tick     (tick),
            .busy     (txn_busy[p]),
            .done     (txn_done[p]),
            .clr      (wd_clr),
            .timed_out(timeout_vec[p])
        );
    end

    assign timeout_any = |timeout_vec;

    sr_recovery_fsm #(
        .ROUTE_HOLD_IVALS(ROUTE_HOLD_IVALS),
        .SLOW_HOLD_IVALS (SLOW_HOLD_IVALS),
        .RECUR_WIN_IVALS (RECUR_WIN_IVALS)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick        (tick),
        .any_order   (|misspec_order),
        .any_race    (|misspec_race),
        .any_timeout (timeout_any),
        .recover_done(recover_done),
        .recover_req (recover_req),
        .route_dis   (adaptive_route_dis),
        .slow_mode   (slow_mode),
        .wd_clr      (wd_clr)
    );

    assign txn_limit = slow_mode ? SLOW_V : FULL_V;

endmodule

// File: rtl/sr_recovery_checker.sv
// Property checker for spec_recovery_ctrl, attached by bind.
// Tracks pending recoveries on its own and checks pulse shape, cause,
// exclusivity and the edges at which the holds may begin.
module sr_recovery_checker #(
    parameter int NUM_PROC   = 4,
    parameter int LIMIT_W    = 5,
    parameter int SLOW_LIMIT = 1
) (
    input logic                clk,
    input logic                rst_n,
    input logic [NUM_PROC-1:0] misspec_order,
    input logic [NUM_PROC-1:0] misspec_race,
    input logic                timeout_any,
    input logic                recover_done,
    input logic                recover_req,
    input logic                adaptive_route_dis,
    input logic [LIMIT_W-1:0]  txn_limit
);
    localparam logic [LIMIT_W-1:0] SLOW_V = LIMIT_W'(SLOW_LIMIT);

    logic pend_q;

    // Independent record of whether a rollback is awaiting completion
    always_ff @(posedge clk) begin
        if (!rst_n)            pend_q <= 1'b0;
        else if (recover_done) pend_q <= 1'b0;
        else if (recover_req)  pend_q <= 1'b1;
    end

    assert_req_one_cycle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        recover_req |=> !recover_req);

    assert_req_has_cause_R2: assert property (@(posedge clk) disable iff (!rst_n)
        recover_req |-> $past((|misspec_order) || (|misspec_race) || timeout_any));

    assert_no_req_while_pending_R3: assert property (@(posedge clk) disable iff (!rst_n)
        recover_req |-> !pend_q);

    assert_route_starts_on_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(adaptive_route_dis) |-> $past(recover_done));

    assert_slow_starts_on_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (txn_limit == SLOW_V && $past(txn_limit) != SLOW_V) |-> $past(recover_done));

endmodule

bind spec_recovery_ctrl sr_recovery_checker #(
    .NUM_PROC  (NUM_PROC),
    .LIMIT_W   (LIMIT_W),
    .SLOW_LIMIT(SLOW_LIMIT)
) u_chk (
    .clk               (clk),
    .rst_n             (rst_n),
    .misspec_order     (misspec_order),
    .misspec_race      (misspec_race),
    .timeout_any       (timeout_any),
    .recover_done      (recover_done),
    .recover_req       (recover_req),
    .adaptive_route_dis(adaptive_route_dis),
    .txn_limit         (txn_limit)
);

// File: tb/spec_recovery_ctrl_bench.sv
// Self-checking bench: a scenario table walked by one loop, then directed
// tests for reset, ignored inputs, watchdog timing and hold expiry.
module spec_recovery_ctrl_bench;
    localparam int NP    = 4;
    localparam int C     = 10;
    localparam int TO    = 3;
    localparam int RHOLD = 2;
    localparam int SHOLD = 2;
    localparam int RWIN  = 4;
    localparam int MAXO  = 8;
    localparam int SLOWL = 1;
    localparam int LW    = $clog2(MAXO + 1);

    // Scenario: [7:6] kind (0 order flag, 1 race flag, 2 timeout),
    // [5:2] quiet intervals before trigger, [1] expected routing disable,
    // [0] expected slow-start
    localparam logic [7:0] SCN [6] = '{
        {2'd0, 4'd8, 1'b1, 1'b0},
        {2'd1, 4'd8, 1'b0, 1'b0},
        {2'd1, 4'd0, 1'b0, 1'b1},
        {2'd2, 4'd8, 1'b0, 1'b0},
        {2'd0, 4'd0, 1'b1, 1'b1},
        {2'd1, 4'd8, 1'b0, 1'b0}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NP-1:0] txn_busy = '0;
    logic [NP-1:0] txn_done = '0;
    logic [NP-1:0] misspec_order = '0;
    logic [NP-1:0] misspec_race = '0;
    logic          recover_done = 1'b0;
    logic          recover_req;
    logic          adaptive_route_dis;
    logic [LW-1:0] txn_limit;

    int  errors = 0;
    int  checks = 0;
    int  req_count = 0;
    bit  finished = 1'b0;

    always #5 clk = ~clk;

    spec_recovery_ctrl #(
        .NUM_PROC(NP), .CKPT_CYCLES(C), .TIMEOUT_IVALS(TO),
        .ROUTE_HOLD_IVALS(RHOLD), .SLOW_HOLD_IVALS(SHOLD),
        .RECUR_WIN_IVALS(RWIN), .MAX_OUTSTANDING(MAXO), .SLOW_LIMIT(SLOWL)
    ) u_spec_recovery_ctrl (
        .clk(clk), .rst_n(rst_n), .txn_busy(txn_busy), .txn_done(txn_done),
        .misspec_order(misspec_order), .misspec_race(misspec_race),
        .recover_done(recover_done), .recover_req(recover_req),
        .adaptive_route_dis(adaptive_route_dis), .txn_limit(txn_limit)
    );

    // Count cycles in which the rollback request is high
    always @(posedge clk) if (rst_n && recover_req) req_count <= req_count + 1;

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // Trigger one recovery of the given kind, verify the pulse, complete it
    task automatic recover(input int kind, input int proc, input bit keep_busy);
        int base;
        int k;
        base = req_count;
        k = 0;
        if (kind == 2) begin
            txn_busy[proc] = 1'b1;
            for (int i = 1; i <= 40; i++) begin
                @(negedge clk);
                if (recover_req) begin k = i; break; end
            end
            chk("R5 timeout not before two intervals", int'(k > 2*C - 1), 1);
            chk("R5 timeout by three intervals", int'(k != 0 && k <= 3*C + 3), 1);
        end else begin
            if (kind == 0) misspec_order[proc] = 1'b1;
            else           misspec_race[proc] = 1'b1;
            @(negedge clk);
            misspec_order = '0;
            misspec_race = '0;
            chk("R2 pulse follows flag", int'(recover_req), 1);
        end
        @(negedge clk);
        chk("R2 pulse lasts one cycle", int'(recover_req), 0);
        recover_done = 1'b1;
        if (!keep_busy) txn_busy = '0;
        @(negedge clk);
        recover_done = 1'b0;
        chk("R2 exactly one pulse per trigger", req_count - base, 1);
    endtask

    initial begin
        int  kind;
        int  gap;
        bit  exp_route;
        bit  exp_slow;
        int  base;

        idle(3);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 recover_req after reset", int'(recover_req), 0);
        chk("R1 route disable after reset", int'(adaptive_route_dis), 0);
        chk("R1 limit after reset", int'(txn_limit), MAXO);

        // Scenario table
        for (int s = 0; s < 6; s++) begin
            kind      = int'(SCN[s][7:6]);
            gap       = int'(SCN[s][5:2]);
            exp_route = SCN[s][1];
            exp_slow  = SCN[s][0];
            idle(gap * C);
            recover(kind, s % NP, 1'b0);
            // R7/R8 routing disable by cause, R9/R10 resume or slow-start
            chk(exp_route ? "R7 route disabled after order recovery"
                          : "R8 route kept after other recovery",
                int'(adaptive_route_dis), int'(exp_route));
            chk(exp_slow ? "R10 slow-start on recurrence"
                         : "R9 plain resume",
                int'(txn_limit), exp_slow ? SLOWL : MAXO);
        end

        // R10 and R7 hold expiry: last table entry was plain, make a recurrence
        idle(8 * C);
        recover(0, 1, 1'b0);
        recover(0, 2, 1'b0);
        chk("R10 slow-start entered", int'(txn_limit), SLOWL);
        idle(C - 2);
        chk("R7 route still disabled within first interval", int'(adaptive_route_dis), 1);
        chk("R10 slow-start still held within first interval", int'(txn_limit), SLOWL);
        idle(C + 4);
        chk("R7 route re-enabled after hold", int'(adaptive_route_dis), 0);
        chk("R10 limit restored after hold", int'(txn_limit), MAXO);

        // R3 triggers ignored while recovery pending
        idle(8 * C);
        base = req_count;
        misspec_race[0] = 1'b1;
        @(negedge clk);
        misspec_race = '0;
        misspec_order[3] = 1'b1;
        @(negedge clk);
        misspec_order = '0;
        misspec_race[1] = 1'b1;
        @(negedge clk);
        misspec_race = '0;
        idle(2);
        chk("R3 no second pulse while pending", req_count - base, 1);
        recover_done = 1'b1;
        @(negedge clk);
        recover_done = 1'b0;
        chk("R3 ignored order flag does not disable routing", int'(adaptive_route_dis), 0);

        // R4 stray completion ignored, not counted for recurrence
        idle(8 * C);
        base = req_count;
        recover_done = 1'b1;
        @(negedge clk);
        recover_done = 1'b0;
        idle(2);
        chk("R4 stray done raises no pulse", req_count - base, 0);
        chk("R4 stray done leaves limit", int'(txn_limit), MAXO);
        recover(1, 0, 1'b0);
        chk("R4 stray done not a recurrence", int'(txn_limit), MAXO);

        // R6 completing transactions and idle processors never time out
        idle(8 * C);
        base = req_count;
        txn_busy[3] = 1'b1;
        for (int r = 0; r < 6; r++) begin
            idle(14);
            txn_done[3] = 1'b1;
            @(negedge clk);
            txn_done[3] = 1'b0;
        end
        txn_busy = '0;
        idle(5 * C);
        chk("R6 no timeout while transactions complete", req_count - base, 0);

        // R11 watchdog restarts after recovery with transaction still busy
        recover(2, 2, 1'b1);
        base = req_count;
        idle(2 * C - 1);
        chk("R11 watchdog restarted after recovery", req_count - base, 0);
        txn_busy = '0;
        idle(3 * C);
        chk("R11 no pulse after busy dropped", req_count - base, 0);

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    // Watchdog for a hung run
    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule